// File: doc/BRIEF.md
# Tuning Window Phase Selector

After a receive-clock tuning sweep, a host controller knows which of its 16 sampling phases delivered a good tuning block. This block turns that pass set into a single robust phase. The passing phases are split into runs of consecutive values. The 16 phases are treated as a ring, so a run that starts at phase 0 is joined to the run that ends at phase 15. The longest run is then chosen, and the phase three quarters of the way into it is returned. That position sits away from the early edge of the eye without being pushed right against the late edge.

The pass set can arrive in two ways. In one, it is a 16-bit mask that the block walks one bit per clock. In the other, the caller announces a count and then streams the passing phases in ascending order, one per clock at most. After loading, the block scans a fixed number of run slots, one per clock. It registers the phase and the error flag, and one cycle later it pulses done. The result is held until the next job completes. Start requests that arrive while a job is in progress are dropped.

Top module: `tws_top`

## Requirements
- R1: Out of reset, phase_o, err_o and done_o are all 0.
- R2: In mask mode, a mask_go_i pulse while idle samples mask_i, and bit k set means phase k passed. The passing phases are taken in ascending order. An all-zero mask ends with err_o=1.
- R3: In list mode, a list_go_i pulse while idle samples cnt_i. A count of 0 or above 16 ends with err_o=1 and done_o high on the third clock after the request. Otherwise exactly cnt_i phases are then taken from ent_i on cycles with ent_vld_i high, and gaps between entries are allowed.
- R4: A new run begins at every entry that is not exactly one greater than the entry before it. A drop or a repeat also starts a new run.
- R5: If the first entry is phase 0 and a later run holds phase 15, the two runs form one run. Its elements are the 15-run's elements followed by the 0-run's elements, and it keeps the 15-run's place in run order. The 0-run then counts as empty.
- R6: The longest run is chosen with a strict greater-than test in run order, so on equal lengths the earliest run wins.
- R7: For a chosen run of length L, the index is floor(3L/4), less one when that value is nonzero, and phase_o is the element at that index (a full mask gives 11, a single phase gives that phase).
- R8: done_o is high for exactly one cycle, in the cycle after phase_o and err_o take their new values. Both outputs then hold until the next result, and phase_o is 0 whenever err_o is 1.
- R9: mask_go_i and list_go_i are ignored while a job is running: the running job's result is unchanged and only one done_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_go_i | input | 1 | Start a job from mask_i |
| mask_i | input | 16 | Pass mask, bit k = phase k passed |
| list_go_i | input | 1 | Start a list job of cnt_i entries |
| cnt_i | input | 6 | Number of list entries to follow |
| ent_vld_i | input | 1 | ent_i holds the next list entry |
| ent_i | input | 4 | Passing phase, ascending order |
| phase_o | output | 4 | Selected phase |
| err_o | output | 1 | Job was rejected |
| done_o | output | 1 | One-cycle result pulse |

## Verification
The hardest case to reach is the ring join, because it fires only when the first entry is phase 0 and a later run contains phase 15. The reordered elements matter only when the chosen index falls inside the 0-run part. Masks 0xC003 and 0x8F01 cover both outcomes. In the first, the joined run wins and the index lands past the 15-run elements. In the second, a longer middle run beats the joined run. Dropping a start request during a job needs a second go pulse timed inside the load window, and the bench then watches for any extra done pulse.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SCAN,
    S_PICK,
    S_DONE
  } tws_state_e;
endpackage

// File: rtl/tws_runs.sv
module tws_runs #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [PW-1:0]            ph_i,
  output logic [NPH-1:0][PW-1:0]   list_o,
  output logic [NPH-1:0][PW:0]     len_o,
  output logic [NPH-1:0][PW-1:0]   st_o,
  output logic [PW:0]              n_o,
  output logic [PW-1:0]            r15_o,
  output logic                     f15_o
);
  localparam logic [PW-1:0] MAXP = PW'(NPH - 1);

  logic [NPH-1:0][PW-1:0] list_q, st_q;
  logic [NPH-1:0][PW:0]   len_q;
  logic [PW:0]            n_q;
  logic [PW-1:0]          row_q, last_q, r15_q;
  logic                   f15_q;
  logic                   seq_w;

  assign seq_w = ({1'b0, ph_i} == ({1'b0, last_q} + (PW+1)'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      list_q <= '0; st_q <= '0; len_q <= '0; n_q <= '0;
      row_q <= '0; last_q <= '0; r15_q <= '0; f15_q <= 1'b0;
    end else if (clr_i) begin
      list_q <= '0; st_q <= '0; len_q <= '0; n_q <= '0;
      row_q <= '0; last_q <= '0; r15_q <= '0; f15_q <= 1'b0;
    end else if (push_i && (n_q != (PW+1)'(NPH))) begin
      list_q[n_q[PW-1:0]] <= ph_i;
      last_q <= ph_i;
      n_q    <= n_q + (PW+1)'(1);
      if (n_q == '0) begin
        len_q[0] <= (PW+1)'(1);
      end else if (seq_w) begin
        len_q[row_q] <= len_q[row_q] + (PW+1)'(1);
        if (ph_i == MAXP && row_q != '0) begin
          r15_q <= row_q; f15_q <= 1'b1;
        end
      end else begin
        // open the next run slot
        len_q[row_q + PW'(1)] <= (PW+1)'(1);
        st_q[row_q + PW'(1)]  <= n_q[PW-1:0];
        row_q <= row_q + PW'(1);
        if (ph_i == MAXP) begin
          r15_q <= row_q + PW'(1); f15_q <= 1'b1;
        end
      end
    end
  end

  assign list_o = list_q;
  assign len_o  = len_q;
  assign st_o   = st_q;
  assign n_o    = n_q;
  assign r15_o  = r15_q;
  assign f15_o  = f15_q;
endmodule

// File: rtl/tws_scan.sv
module tws_scan #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [PW:0]   len_i,
  output logic [PW-1:0] k_o,
  output logic          last_o,
  output logic [PW:0]   best_len_o,
  output logic [PW-1:0] best_k_o
);
  logic [PW-1:0] k_q, bk_q;
  logic [PW:0]   bl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0; bk_q <= '0; bl_q <= '0;
    end else if (clr_i) begin
      k_q <= '0; bk_q <= '0; bl_q <= '0;
    end else if (step_i) begin
      k_q <= k_q + PW'(1);
      if (len_i > bl_q) begin  // strict: earliest run keeps a tie
        bl_q <= len_i;
        bk_q <= k_q;
      end
    end
  end

  assign k_o        = k_q;
  assign last_o     = (k_q == PW'(NPH - 1));
  assign best_len_o = bl_q;
  assign best_k_o   = bk_q;
endmodule

// File: rtl/tws_top.sv
module tws_top
  import tws_pkg::*;
#(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int CW  = PW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mask_go_i,
  input  logic [NPH-1:0] mask_i,
  input  logic           list_go_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           ent_vld_i,
  input  logic [PW-1:0]  ent_i,
  output logic [PW-1:0]  phase_o,
  output logic           err_o,
  output logic           done_o
);
  localparam logic [PW-1:0] MAXP = PW'(NPH - 1);

  tws_state_e state_q;
  logic           mode_q, bad_q, done_q, err_q;
  logic [NPH-1:0] msk_q;
  logic [PW-1:0]  bit_q, phase_q;
  logic [CW-1:0]  cnt_q;

  logic idle_w, clr_w, push_w, step_w, last_w, f15_w, merged_w, merr_w, err_w;
  logic [PW-1:0] ph_w, r15_w, k_w, bk_w, idx_w, pick_w;
  logic [PW:0]   n_w, eff_w, bl_w;
  logic [PW+1:0] sum_w;
  logic [PW+2:0] q3_w;
  logic [NPH-1:0][PW-1:0] list_w, st_w;
  logic [NPH-1:0][PW:0]   len_w;

  assign idle_w = (state_q == S_IDLE);
  assign clr_w  = idle_w && (mask_go_i || list_go_i);
  assign push_w = (state_q == S_LOAD) && (mode_q ? ent_vld_i : msk_q[bit_q]);
  assign ph_w   = mode_q ? ent_i : bit_q;
  assign step_w = (state_q == S_SCAN);

  tws_runs #(.NPH(NPH), .PW(PW)) u_runs (
    .clk_i, .rst_ni, .clr_i(clr_w), .push_i(push_w), .ph_i(ph_w),
    .list_o(list_w), .len_o(len_w), .st_o(st_w), .n_o(n_w),
    .r15_o(r15_w), .f15_o(f15_w)
  );

  // ring join: 0-run emptied, 15-run slot carries both
  assign merged_w = (n_w != '0) && (list_w[0] == '0) && f15_w;
  assign sum_w    = {1'b0, len_w[0]} + {1'b0, len_w[r15_w]};
  assign merr_w   = merged_w && (sum_w >= (PW+2)'(NPH));
  always_comb begin
    eff_w = len_w[k_w];
    if (merged_w) begin
      if (k_w == '0)        eff_w = '0;
      else if (k_w == r15_w) eff_w = sum_w[PW:0];
    end
  end

  tws_scan #(.NPH(NPH), .PW(PW)) u_scan (
    .clk_i, .rst_ni, .clr_i(clr_w), .step_i(step_w), .len_i(eff_w),
    .k_o(k_w), .last_o(last_w), .best_len_o(bl_w), .best_k_o(bk_w)
  );

  assign q3_w  = ({2'b00, bl_w} * (PW+3)'(3)) >> 2;
  assign idx_w = (q3_w != '0) ? PW'(q3_w - (PW+3)'(1)) : '0;
  always_comb begin
    pick_w = list_w[st_w[bk_w] + idx_w];
    if (merged_w && bk_w == r15_w) begin
      if ({1'b0, idx_w} < len_w[r15_w]) pick_w = list_w[st_w[r15_w] + idx_w];
      else                              pick_w = list_w[idx_w - len_w[r15_w][PW-1:0]];
    end
  end
  assign err_w = bad_q || (n_w == '0) || merr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; mode_q <= 1'b0; bad_q <= 1'b0; msk_q <= '0;
      bit_q <= '0; cnt_q <= '0; phase_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (mask_go_i) begin
            mode_q <= 1'b0; msk_q <= mask_i; bit_q <= '0; bad_q <= 1'b0;
            state_q <= S_LOAD;
          end else if (list_go_i) begin
            mode_q <= 1'b1; cnt_q <= cnt_i;
            if (cnt_i == '0 || cnt_i > CW'(NPH)) begin
              bad_q <= 1'b1; state_q <= S_PICK;
            end else begin
              bad_q <= 1'b0; state_q <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (!mode_q) begin
            bit_q <= bit_q + PW'(1);
            if (bit_q == MAXP) state_q <= S_SCAN;
          end else if (ent_vld_i && ({1'b0, n_w} + CW'(1)) == cnt_q) begin
            state_q <= S_SCAN;
          end
        end
        S_SCAN: if (last_w) state_q <= S_PICK;
        S_PICK: begin
          phase_q <= err_w ? '0 : pick_w;
          err_q   <= err_w;
          state_q <= S_DONE;
        end
        S_DONE: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign err_o   = err_q;
  assign done_o  = done_q;
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int CW  = PW + 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          idle_i,
  input logic          mask_go_i,
  input logic          list_go_i,
  input logic [CW-1:0] cnt_i,
  input logic [PW-1:0] phase_o,
  input logic          err_o,
  input logic          done_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($stable(phase_o) && $stable(err_o)));  // R8
  AST_ERR_ZERO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (phase_o == '0));  // R8
  AST_PHASE_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> ##1 done_o);  // R8
  AST_BAD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !mask_go_i && list_go_i && (cnt_i == '0 || cnt_i > CW'(NPH)))
      |=> ##2 (done_o && err_o));  // R3
endmodule

bind tws_top tws_chk #(.NPH(NPH), .PW(PW), .CW(CW)) u_chk (
  .clk_i, .rst_ni, .idle_i(state_q == tws_pkg::S_IDLE),
  .mask_go_i, .list_go_i, .cnt_i, .phase_o, .err_o, .done_o
);

// File: tb/tws_top_bench.sv
module tws_top_bench;
  localparam int CLK_NS = 10;
  localparam int NPH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mask_go = 1'b0, list_go = 1'b0, ent_vld = 1'b0;
  logic [15:0] mask = '0;
  logic [5:0]  cnt = '0;
  logic [3:0]  ent = '0;
  logic [3:0]  phase;
  logic err, done;
  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  tws_top u_tws_top (
    .clk_i(clk), .rst_ni(rst_n), .mask_go_i(mask_go), .mask_i(mask),
    .list_go_i(list_go), .cnt_i(cnt), .ent_vld_i(ent_vld), .ent_i(ent),
    .phase_o(phase), .err_o(err), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req, output int cyc);
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk({req, " done seen"}, int'(done), 1);
  endtask

  task automatic finish_check(input string req, input int exp_ph, input int exp_err);
    chk({req, " phase"}, int'(phase), exp_ph);
    chk({req, " err"}, int'(err), exp_err);
    @(negedge clk);
    chk({req, " done one cycle"}, int'(done), 0);
  endtask

  task automatic run_mask(input string req, input logic [15:0] m, input int exp_ph, input int exp_err);
    int cyc;
    @(negedge clk); mask = m; mask_go = 1'b1;
    @(negedge clk); mask_go = 1'b0;
    wait_done(req, cyc);
    finish_check(req, exp_ph, exp_err);
  endtask

  task automatic run_list(input string req, input int c, input int n, input logic [3:0] e [16], input int exp_ph, input int exp_err);
    int cyc;
    @(negedge clk); cnt = 6'(c); list_go = 1'b1;
    @(negedge clk); list_go = 1'b0;
    for (int i = 0; i < n; i++) begin
      ent = e[i]; ent_vld = 1'b1;
      @(negedge clk); ent_vld = 1'b0;
      if (i % 2 == 1) @(negedge clk);  // gap between entries
    end
    wait_done(req, cyc);
    finish_check(req, exp_ph, exp_err);
  endtask

  task automatic bad_count(input string req, input int c);
    @(negedge clk); cnt = 6'(c); list_go = 1'b1;
    @(negedge clk); list_go = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({req, " done on third clock"}, int'(done), 1);
    finish_check(req, 0, 1);
  endtask

  task automatic busy_ignore();
    int cyc, extra;
    @(negedge clk); mask = 16'h00F0; mask_go = 1'b1;
    @(negedge clk); mask_go = 1'b0;
    repeat (4) @(negedge clk);
    mask = 16'hFFFF; mask_go = 1'b1; list_go = 1'b1; cnt = 6'd0;
    @(negedge clk); mask_go = 1'b0; list_go = 1'b0;
    wait_done("R9", cyc);
    finish_check("R9", 6, 0);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R9 no second done", extra, 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] e [16];
    repeat (3) @(negedge clk);
    chk("R1 phase", int'(phase), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after release", int'(done), 0);

    run_mask("R7 full mask", 16'hFFFF, 11, 0);
    run_mask("R2 empty mask", 16'h0000, 0, 1);
    run_mask("R2 R7 run 4..7", 16'h00F0, 6, 0);
    run_mask("R7 single phase", 16'h0200, 9, 0);
    run_mask("R6 tie earliest", 16'h0E0E, 2, 0);
    run_mask("R5 ring join", 16'hC003, 0, 0);
    run_mask("R5 R6 middle run wins", 16'h8F01, 10, 0);
    run_mask("R5 no join without phase 0", 16'h8006, 1, 0);

    bad_count("R3 count zero", 0);
    bad_count("R3 count 17", 17);

    e = '{default: 4'd0};
    e[0] = 4'd5; e[1] = 4'd6; e[2] = 4'd7;
    run_list("R3 list 5..7", 3, 3, e, 6, 0);
    e[0] = 4'd3; e[1] = 4'd4; e[2] = 4'd9; e[3] = 4'd10; e[4] = 4'd11; e[5] = 4'd12;
    run_list("R4 list split", 6, 6, e, 11, 0);
    e[0] = 4'd2; e[1] = 4'd3; e[2] = 4'd3; e[3] = 4'd4;
    run_list("R4 repeat breaks run", 4, 4, e, 2, 0);

    busy_ignore();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule